// File: doc/BRIEF.md
# Zero-Overhead Nested Loop Sequencer

This block drives the fetch address of a program sequencer and runs nested hardware loops, so the loop itself costs no branch instructions. It holds the 16-bit fetch address, the stored loop-end address, the remaining iteration count and a loop-active flag. It also keeps a two-entry state machine handshake with an external two-half system stack: each stack word has an upper half and a lower half, both `W` bits wide.

A DO command starts a loop. It saves the current loop context on the stack, records where the loop starts, loads the new count and end address, and sets the loop-active flag. Each fetch step moves the fetch address. When the word at the stored end address is consumed, the block either jumps back to the loop start with no lost cycle, or, on the final pass, falls through and restores the enclosing loop's context from the stack. An ENDDO command restores the enclosing context early and leaves the fetch address where it is.

States and transitions of the controller:
- RUN to PUSH_PC when a DO is accepted. The saved loop-end address and count are pushed in this cycle.
- PUSH_PC to RUN in all cases. The start address and the status word are pushed, and the new loop is loaded.
- RUN to POP_SR on an ENDDO while the loop-active flag is set, or on a step that consumes the final word of the last pass.
- POP_SR to POP_CTX in all cases. The first pop recovers the status word.
- POP_CTX to RUN in all cases. The second pop recovers the saved loop-end address and count.
- RUN to RUN for every other case: a plain step, a step that branches back, or no command.

Top module: `loop_sequencer`

## Requirements
- R1: After reset the fetch address is 0, the loop-active output is 0, busy is 0, and neither push nor pop is asserted.
- R2: An accepted DO makes two pushes in two consecutive cycles, with busy high between them. The first push carries the old stored end address in the upper half and the old count in the lower half. The second push carries the current fetch address in the upper half and the status word in the lower half, with the loop-active flag at bit 0 and all other bits zero. Loop-active is then 1.
- R3: The stored end address is the supplied end address minus one. The last word of the loop body is therefore at supplied end minus one.
- R4: A supplied count of 0 is stored as 65535 (0xFFFF).
- R5: While loop-active is 0, each step advances the fetch address by one, whatever the stored end address holds.
- R6: A step at the stored end address with a count other than 1 decrements the count and reloads the fetch address from the upper half of the stack top. No pop is made.
- R7: A step at the stored end address with a count of 1 moves the fetch address to end plus one. Two pops follow. The first pop restores the loop-active flag from bit 0 of its lower half. The second pop restores the stored end address from its upper half and the count from its lower half, so an enclosing loop resumes.
- R8: ENDDO while loop-active is 1 performs the same two-pop restore and leaves the fetch address unchanged. ENDDO while loop-active is 0 has no effect.
- R9: While busy, steps, DO and ENDDO are ignored and the fetch address holds. In RUN, DO takes priority over ENDDO and step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One instruction word consumed at `pc_o` this cycle |
| do_i | input | 1 | Start a loop |
| enddo_i | input | 1 | Abandon the current loop |
| do_count_i | input | W | Iteration count for DO |
| do_end_i | input | W | Loop end address for DO, one past the last body word |
| stk_push_o | output | 1 | Push a word onto the system stack |
| stk_pop_o | output | 1 | Pop the stack top |
| stk_wr_hi_o | output | W | Upper half of the pushed word |
| stk_wr_lo_o | output | W | Lower half of the pushed word |
| stk_rd_hi_i | input | W | Upper half of the current stack top |
| stk_rd_lo_i | input | W | Lower half of the current stack top |
| pc_o | output | W | Current fetch address |
| loop_active_o | output | 1 | Loop-active flag |
| busy_o | output | 1 | Push or pop sequence in progress |

## Verification
A sweep over counts 1 to 4 and body lengths 1 to 3 checks every fetch address against the arithmetic pattern start plus (k mod length). A design that forgot the end-address decrement would run one word too far on each pass, and an off-by-one in the count test would run one pass too many or too few. A two-level nest checks that the inner exit returns the outer loop's end address and count intact. Swapped pop halves or a missing status restore would break the outer loop's second pass. Separate cases cover count 0 (observed as 0xFFFF in the saved lower half), an ENDDO in mid-loop followed by fetching past the old end with no branch, an ENDDO with no loop active (which a faulty design would turn into a stack underflow), and step/DO/ENDDO collisions while busy.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [1:0] {
        S_RUN,
        S_PUSH_PC,
        S_POP_SR,
        S_POP_CTX
    } lsq_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_BACK,
        OP_SAVE,
        OP_LOAD,
        OP_RST_SR,
        OP_RST_CTX
    } lsq_op_e;

endpackage

// File: rtl/lsq_compare.sv
module lsq_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] la,
    input  logic [W-1:0] lc,
    input  logic         lf,
    output logic         at_end,
    output logic         last_pass
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        at_end    = lf && (pc == la);
        last_pass = (lc == ONE);
    end
endmodule

// File: rtl/lsq_fsm.sv
module lsq_fsm
    import lsq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      do_i,
    input  logic      enddo_i,
    input  logic      step_i,
    input  logic      lf,
    input  logic      at_end,
    input  logic      last_pass,
    output lsq_op_e   op,
    output logic      push,
    output logic      pop,
    output logic      sel_pc,
    output logic      busy
);
    lsq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN: begin
                if (do_i)                         state_d = S_PUSH_PC;
                else if (enddo_i && lf)           state_d = S_POP_SR;
                else if (step_i && at_end && last_pass) state_d = S_POP_SR;
            end
            S_PUSH_PC: state_d = S_RUN;
            S_POP_SR:  state_d = S_POP_CTX;
            S_POP_CTX: state_d = S_RUN;
        endcase
    end

    always_comb begin
        op     = OP_HOLD;
        push   = 1'b0;
        pop    = 1'b0;
        sel_pc = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            S_RUN: begin
                busy = 1'b0;
                if (do_i) begin
                    op   = OP_SAVE;
                    push = 1'b1;
                end else if (enddo_i && lf) begin
                    op = OP_HOLD;
                end else if (step_i) begin
                    op = (at_end && !last_pass) ? OP_BACK : OP_STEP;
                end
            end
            S_PUSH_PC: begin
                op     = OP_LOAD;
                push   = 1'b1;
                sel_pc = 1'b1;
            end
            S_POP_SR: begin
                op  = OP_RST_SR;
                pop = 1'b1;
            end
            S_POP_CTX: begin
                op  = OP_RST_CTX;
                pop = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lsq_regs.sv
module lsq_regs
    import lsq_pkg::*;
#(
    parameter int W      = 16,
    parameter int LF_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lsq_op_e      op,
    input  logic         sel_pc,
    input  logic [W-1:0] do_count,
    input  logic [W-1:0] do_end,
    input  logic [W-1:0] rd_hi,
    input  logic [W-1:0] rd_lo,
    output logic [W-1:0] pc,
    output logic [W-1:0] la,
    output logic [W-1:0] lc,
    output logic         lf,
    output logic [W-1:0] wr_hi,
    output logic [W-1:0] wr_lo
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] pend_cnt, pend_end;
    logic [W-1:0] sr_word;

    always_comb begin
        sr_word         = '0;
        sr_word[LF_BIT] = lf;
        wr_hi = sel_pc ? pc : la;
        wr_lo = sel_pc ? sr_word : lc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            la       <= '0;
            lc       <= '0;
            lf       <= 1'b0;
            pend_cnt <= '0;
            pend_end <= '0;
        end else begin
            case (op)
                OP_STEP: pc <= pc + ONE;
                OP_BACK: begin
                    pc <= rd_hi;
                    lc <= lc - ONE;
                end
                OP_SAVE: begin
                    pend_cnt <= do_count;
                    pend_end <= do_end;
                end
                OP_LOAD: begin
                    lc <= (pend_cnt == '0) ? ONES : pend_cnt;
                    la <= pend_end - ONE;
                    lf <= 1'b1;
                end
                OP_RST_SR:  lf <= rd_lo[LF_BIT];
                OP_RST_CTX: begin
                    la <= rd_hi;
                    lc <= rd_lo;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
    import lsq_pkg::*;
#(
    parameter int W      = 16,
    parameter int LF_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         do_i,
    input  logic         enddo_i,
    input  logic [W-1:0] do_count_i,
    input  logic [W-1:0] do_end_i,
    output logic         stk_push_o,
    output logic         stk_pop_o,
    output logic [W-1:0] stk_wr_hi_o,
    output logic [W-1:0] stk_wr_lo_o,
    input  logic [W-1:0] stk_rd_hi_i,
    input  logic [W-1:0] stk_rd_lo_i,
    output logic [W-1:0] pc_o,
    output logic         loop_active_o,
    output logic         busy_o
);
    lsq_op_e      op;
    logic         sel_pc, at_end, last_pass;
    logic [W-1:0] pc_q, la_q, lc_q;
    logic         lf_q;

    lsq_compare #(.W(W)) u_cmp (
        .pc(pc_q), .la(la_q), .lc(lc_q), .lf(lf_q),
        .at_end(at_end), .last_pass(last_pass)
    );

    lsq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .do_i(do_i), .enddo_i(enddo_i),
        .step_i(step_i), .lf(lf_q), .at_end(at_end), .last_pass(last_pass),
        .op(op), .push(stk_push_o), .pop(stk_pop_o), .sel_pc(sel_pc),
        .busy(busy_o)
    );

    lsq_regs #(.W(W), .LF_BIT(LF_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .op(op), .sel_pc(sel_pc),
        .do_count(do_count_i), .do_end(do_end_i),
        .rd_hi(stk_rd_hi_i), .rd_lo(stk_rd_lo_i),
        .pc(pc_q), .la(la_q), .lc(lc_q), .lf(lf_q),
        .wr_hi(stk_wr_hi_o), .wr_lo(stk_wr_lo_o)
    );

    assign pc_o          = pc_q;
    assign loop_active_o = lf_q;
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_i,
    input logic         do_i,
    input logic         enddo_i,
    input logic         stk_push_o,
    input logic         stk_pop_o,
    input logic [W-1:0] pc_o,
    input logic         busy_o,
    input logic         lf,
    input logic [W-1:0] lc
);
    // R2: an accepted DO leads to a second push while busy
    p_do_second_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && do_i) |=> (busy_o && stk_push_o));

    // R4: an active loop never holds a zero count
    p_lc_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lf && !busy_o) |-> (lc != '0));

    // R5: plain step with no active loop advances by one
    p_plain_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !lf && step_i && !do_i) |=> (pc_o == $past(pc_o) + W'(1)));

    // R7: push and pop never coincide
    p_push_pop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push_o && stk_pop_o));

    // R8: ENDDO with no active loop leaves the controller idle
    p_enddo_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !lf && enddo_i && !do_i) |=> !busy_o);

    // R9: fetch address holds across busy cycles
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(pc_o));
endmodule

bind loop_sequencer lsq_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .do_i(do_i),
    .enddo_i(enddo_i), .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o),
    .pc_o(pc_o), .busy_o(busy_o), .lf(lf_q), .lc(lc_q)
);

// File: tb/loop_sequencer_test.sv
module loop_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, do_i = 1'b0, enddo_i = 1'b0;
    logic [15:0] do_count_i = '0, do_end_i = '0;
    logic        stk_push_o, stk_pop_o;
    logic [15:0] stk_wr_hi_o, stk_wr_lo_o, stk_rd_hi_i, stk_rd_lo_i;
    logic [15:0] pc_o;
    logic        loop_active_o, busy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    loop_sequencer uut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .do_i(do_i),
        .enddo_i(enddo_i), .do_count_i(do_count_i), .do_end_i(do_end_i),
        .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o),
        .stk_wr_hi_o(stk_wr_hi_o), .stk_wr_lo_o(stk_wr_lo_o),
        .stk_rd_hi_i(stk_rd_hi_i), .stk_rd_lo_i(stk_rd_lo_i),
        .pc_o(pc_o), .loop_active_o(loop_active_o), .busy_o(busy_o)
    );

    // behavioural stack
    logic [15:0] shi [16];
    logic [15:0] slo [16];
    logic [4:0]  sp;
    logic [3:0]  top_idx;
    assign top_idx     = sp[3:0] - 4'd1;
    assign stk_rd_hi_i = (sp == 0) ? 16'h0 : shi[top_idx];
    assign stk_rd_lo_i = (sp == 0) ? 16'h0 : slo[top_idx];

    always @(posedge clk) begin
        if (!rst_n) sp <= '0;
        else if (stk_push_o) begin
            shi[sp[3:0]] <= stk_wr_hi_o;
            slo[sp[3:0]] <= stk_wr_lo_o;
            sp <= sp + 5'd1;
        end else if (stk_pop_o) sp <= sp - 5'd1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic step_expect(input logic [15:0] exp, input string req);
        chk(pc_o == exp && !busy_o, req, {15'b0, busy_o, pc_o}, {16'b0, exp});
        step_i = 1'b1;
        tick();
        step_i = 1'b0;
    endtask

    task automatic issue_do(input logic [15:0] cnt, input logic [15:0] e);
        do_i = 1'b1; do_count_i = cnt; do_end_i = e;
        tick();
        do_i = 1'b0;
        tick();
    endtask

    task automatic issue_enddo();
        enddo_i = 1'b1;
        tick();
        enddo_i = 1'b0;
        tick();
        tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] s;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(pc_o == 0, "R1", pc_o, 0);
        chk(!loop_active_o && !busy_o && !stk_push_o && !stk_pop_o, "R1",
            {busy_o, loop_active_o}, 0);

        // R5: stored end address 0 must not branch while inactive
        for (int k = 0; k < 4; k++) step_expect(16'(k), "R5");
        chk(pc_o == 4, "R5", pc_o, 4);

        // sweep: counts 1..4, body lengths 1..3
        for (int cnt = 1; cnt <= 4; cnt++) begin
            for (int len = 1; len <= 3; len++) begin
                s = pc_o;
                issue_do(16'(cnt), s + 16'(len));
                chk(!busy_o && loop_active_o && sp == 2, "R2", {sp, loop_active_o}, {5'd2, 1'b1});
                chk(shi[1] == s && slo[1] == 0, "R2", {shi[1], slo[1]}, {s, 16'h0});
                chk(shi[0] == 0 && slo[0] == 0, "R2", {shi[0], slo[0]}, 0);
                for (int k = 0; k < cnt * len; k++)
                    step_expect(s + 16'(k % len), (k % len == len - 1) ? "R3" : "R6");
                tick(); tick();
                chk(pc_o == s + 16'(len) && !loop_active_o && !busy_o && sp == 0, "R7",
                    {sp, loop_active_o, pc_o}, {5'd0, 1'b0, s + 16'(len)});
            end
        end

        // R9: DO with simultaneous step and ENDDO, step held while busy
        s = pc_o;
        do_i = 1'b1; step_i = 1'b1; enddo_i = 1'b1; do_count_i = 2; do_end_i = s + 2;
        tick();
        do_i = 1'b0; enddo_i = 1'b0;
        chk(busy_o, "R9", busy_o, 1);
        tick();
        step_i = 1'b0;
        chk(pc_o == s && loop_active_o && sp == 2, "R9", {sp, pc_o}, {5'd2, s});
        for (int k = 0; k < 4; k++) step_expect(s + 16'(k % 2), "R6");
        tick(); tick();
        chk(pc_o == s + 2 && !loop_active_o, "R7", pc_o, s + 2);

        // nested loops
        s = pc_o;
        issue_do(2, s + 10);
        for (int pass = 0; pass < 2; pass++) begin
            step_expect(s, "R6");
            step_expect(s + 1, "R6");
            issue_do(3, s + 5);
            chk(sp == 4 && slo[3] == 1, "R2", {sp, slo[3]}, {5'd4, 16'd1});
            chk(shi[2] == s + 9 && slo[2] == 16'(2 - pass), "R3",
                {shi[2], slo[2]}, {s + 16'd9, 16'(2 - pass)});
            for (int k = 0; k < 9; k++) step_expect(s + 2 + 16'(k % 3), "R6");
            tick(); tick();
            chk(pc_o == s + 5 && loop_active_o && sp == 2, "R7",
                {sp, loop_active_o, pc_o}, {5'd2, 1'b1, s + 16'd5});
            for (int k = 5; k < 10; k++) step_expect(s + 16'(k), "R3");
            if (pass == 0) chk(pc_o == s, "R6", pc_o, s);
        end
        tick(); tick();
        chk(pc_o == s + 10 && !loop_active_o && sp == 0, "R7",
            {sp, loop_active_o, pc_o}, {5'd0, 1'b0, s + 16'd10});

        // R4: count 0 seen as 0xFFFF when the nest saves it
        s = pc_o;
        issue_do(0, s + 20);
        issue_do(1, s + 2);
        chk(slo[2] == 16'hFFFF, "R4", slo[2], 16'hFFFF);
        chk(shi[2] == s + 19, "R3", shi[2], s + 19);
        step_expect(s, "R7");
        step_expect(s + 1, "R7");
        tick(); tick();
        chk(pc_o == s + 2 && loop_active_o && sp == 2, "R7", {sp, pc_o}, {5'd2, s + 16'd2});
        issue_enddo();
        chk(pc_o == s + 2 && !loop_active_o && sp == 0 && !busy_o, "R8",
            {sp, loop_active_o, pc_o}, {5'd0, 1'b0, s + 16'd2});

        // R8: ENDDO with no active loop is ignored
        s = pc_o;
        enddo_i = 1'b1;
        tick();
        enddo_i = 1'b0;
        chk(!busy_o && !stk_pop_o && sp == 0 && pc_o == s, "R8", {busy_o, sp, pc_o}, {1'b0, 5'd0, s});

        // R8: early exit then fetch past the old end without branching
        s = pc_o;
        issue_do(5, s + 4);
        step_expect(s, "R6");
        step_expect(s + 1, "R6");
        issue_enddo();
        chk(pc_o == s + 2 && !loop_active_o, "R8", pc_o, s + 2);
        for (int k = 2; k < 6; k++) step_expect(s + 16'(k), "R5");
        chk(pc_o == s + 6, "R5", pc_o, s + 6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule